// File: doc/BRIEF.md
# Multi-CPU Level-One Interrupt Aggregator

This block gathers a wide vector of level-sensitive interrupt lines, 32 lines per register word, and drives one interrupt request per CPU. Each CPU has a private register bank on a simple 32-bit register bus. A bank holds one enable register per word and one status register per word. A CPU's request is raised while at least one line is both high and enabled in that CPU's bank.

Software writes the enable words of a CPU to choose which lines that CPU services. It reads the status words to see the raw line levels. Every bank shows the same lines, and the banks differ only in their enables. The bank at the lowest address belongs to CPU 0, and the bank for each later CPU follows it directly. Register word 0 of a bank carries the highest-numbered group of 32 lines. The last word carries lines 0 to 31.

Top module: `l1_irq_agg`

## Requirements
- R1: After reset every enable bit of every CPU is 0, all enable words read back 0, and every `cpu_irq` bit is 0.
- R2: Addresses are byte addresses of 32-bit words. CPU `c` owns the words starting at word index `c*2*N_WORDS`. Its first `N_WORDS` words are the enable words 0..N_WORDS-1, and the next `N_WORDS` words are the status words 0..N_WORDS-1.
- R3: Bit `b` of register word `w`, enable or status, stands for line `(N_WORDS-1-w)*32 + b`, so word 0 holds the top 32 lines.
- R4: A write to an enable address replaces all 32 bits of that word for that CPU only, and a read returns the last value written.
- R5: A status word returns the present level of its 32 lines. The value is the same in every CPU's bank, and writes to status addresses change no enable bit.
- R6: Reads of addresses outside all banks, or with address bits [1:0] not zero, return 0, and writes to them change nothing.
- R7: `cpu_irq[c]` is registered. It equals the OR over all lines of (line level AND CPU `c` enable) as sampled at the previous rising clock edge.
- R8: `bus_rdata` is combinational from `bus_addr`, the enables and `irq_in`, with no read latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_WORDS*32 | Level interrupt lines, index = line number |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cpu_irq | output | N_CPUS | Registered interrupt request per CPU |

## Verification
The checker tests several rules on every cycle. Each request is the registered OR of that CPU's enabled lines. A write reaches at most one bank, and a bank that is not written keeps its enables. A write to a status or unmapped address leaves all enables unchanged, and unmapped reads return zero. The address layout, the big-endian word-to-line mapping, the read-back of whole-word enables and the equal status in every bank are shown only by the bench. The bench sweeps a single raised line across all lines and both CPUs and compares each result with the line and address arithmetic computed from the requirements.

// File: rtl/l1_irq_pkg.sv
package l1_irq_pkg;

  localparam int unsigned LINES_PER_WORD = 32;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_ENABLE = 2'd1,
    REG_STATUS = 2'd2
  } reg_kind_e;

  // Lowest line number carried by register word w (big-endian word order).
  function automatic int unsigned line_base(int unsigned w, int unsigned n_words);
    return (n_words - 1 - w) * LINES_PER_WORD;
  endfunction

  // Number of 32-bit registers in one CPU bank.
  function automatic int unsigned bank_words(int unsigned n_words);
    return 2 * n_words;
  endfunction

endpackage

// File: rtl/l1_irq_decode.sv
module l1_irq_decode
  import l1_irq_pkg::*;
#(
  parameter int unsigned N_CPUS  = 2,
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned CPU_W  = (N_CPUS  > 1) ? $clog2(N_CPUS)  : 1,
  localparam int unsigned WORD_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [CPU_W-1:0]  cpu_sel,
  output logic [WORD_W-1:0] word_sel
);

  localparam int unsigned BANK_W = bank_words(N_WORDS);

  int unsigned widx;
  int unsigned bank;
  int unsigned slot;

  always_comb begin
    widx     = 32'(addr[ADDR_W-1:2]);
    bank     = widx / BANK_W;
    slot     = widx % BANK_W;
    kind     = REG_NONE;
    cpu_sel  = '0;
    word_sel = '0;
    if (addr[1:0] == 2'b00 && bank < N_CPUS) begin
      cpu_sel = CPU_W'(bank);
      if (slot < N_WORDS) begin
        kind     = REG_ENABLE;
        word_sel = WORD_W'(slot);
      end else begin
        kind     = REG_STATUS;
        word_sel = WORD_W'(slot - N_WORDS);
      end
    end
  end

endmodule

// File: rtl/l1_irq_bank.sv
module l1_irq_bank
  import l1_irq_pkg::*;
#(
  parameter int unsigned N_WORDS = 4,
  localparam int unsigned N_LINES = N_WORDS * LINES_PER_WORD,
  localparam int unsigned WORD_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic [31:0]        wr_data,
  input  logic [N_LINES-1:0] irq_in,
  output logic [N_LINES-1:0] en_lines,
  output logic               pending_any,
  output logic               irq_out
);

  logic [31:0] en_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam int unsigned BASE = line_base(w, N_WORDS);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[w] <= '0;
      end else if (wr_en && wr_word == WORD_W'(w)) begin
        en_q[w] <= wr_data;
      end
    end
    assign en_lines[BASE +: LINES_PER_WORD] = en_q[w];
  end

  assign pending_any = |(irq_in & en_lines);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= pending_any;
  end

endmodule

// File: rtl/l1_irq_agg.sv
module l1_irq_agg
  import l1_irq_pkg::*;
#(
  parameter int unsigned N_CPUS  = 2,
  parameter int unsigned N_WORDS = 4,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned N_LINES = N_WORDS * LINES_PER_WORD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [N_CPUS-1:0]  cpu_irq
);

  localparam int unsigned CPU_W  = (N_CPUS  > 1) ? $clog2(N_CPUS)  : 1;
  localparam int unsigned WORD_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int unsigned LINE_W = $clog2(N_LINES);

  reg_kind_e          dec_kind;
  logic [CPU_W-1:0]   dec_cpu;
  logic [WORD_W-1:0]  dec_word;

  // Named events for the checker.
  logic                      dec_enable_hit;
  logic                      dec_status_hit;
  logic                      dec_miss;
  logic [N_CPUS-1:0]         bank_wr;
  logic [N_CPUS-1:0]         bank_pending;
  logic [N_CPUS*N_LINES-1:0] en_flat;
  logic [N_LINES-1:0]        en_all [N_CPUS];
  logic [LINE_W-1:0]         rd_base;

  l1_irq_decode #(
    .N_CPUS (N_CPUS),
    .N_WORDS(N_WORDS),
    .ADDR_W (ADDR_W)
  ) u_decode (
    .addr    (bus_addr),
    .kind    (dec_kind),
    .cpu_sel (dec_cpu),
    .word_sel(dec_word)
  );

  assign dec_enable_hit = (dec_kind == REG_ENABLE);
  assign dec_status_hit = (dec_kind == REG_STATUS);
  assign dec_miss       = (dec_kind == REG_NONE);

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    assign bank_wr[c] = bus_we && dec_enable_hit && (dec_cpu == CPU_W'(c));

    l1_irq_bank #(
      .N_WORDS(N_WORDS)
    ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (bank_wr[c]),
      .wr_word    (dec_word),
      .wr_data    (bus_wdata),
      .irq_in     (irq_in),
      .en_lines   (en_all[c]),
      .pending_any(bank_pending[c]),
      .irq_out    (cpu_irq[c])
    );

    assign en_flat[c*N_LINES +: N_LINES] = en_all[c];
  end

  assign rd_base = LINE_W'(line_base(32'(dec_word), N_WORDS));

  always_comb begin
    bus_rdata = '0;
    unique case (dec_kind)
      REG_ENABLE: bus_rdata = en_all[dec_cpu][rd_base +: LINES_PER_WORD];
      REG_STATUS: bus_rdata = irq_in[rd_base +: LINES_PER_WORD];
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/l1_irq_chk.sv
module l1_irq_chk #(
  parameter int unsigned N_CPUS  = 2,
  parameter int unsigned N_WORDS = 4,
  localparam int unsigned N_LINES = N_WORDS * 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [N_LINES-1:0]        irq_in,
  input logic                      bus_we,
  input logic [31:0]               bus_rdata,
  input logic [N_CPUS-1:0]         cpu_irq,
  input logic                      dec_status_hit,
  input logic                      dec_miss,
  input logic [N_CPUS-1:0]         bank_wr,
  input logic [N_CPUS*N_LINES-1:0] en_flat
);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cpu_irq == '0 && en_flat == '0));

  a_r4_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));

  a_r5_status_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && dec_status_hit) |=> $stable(en_flat));

  a_r6_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> bus_rdata == 32'd0);

  a_r6_miss_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && dec_miss) |=> $stable(en_flat));

  for (genvar c = 0; c < N_CPUS; c++) begin : g_cpu
    a_r7_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cpu_irq[c] == $past(|(irq_in & en_flat[c*N_LINES +: N_LINES])));

    a_r4_other_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_wr[c] |=> $stable(en_flat[c*N_LINES +: N_LINES]));
  end

endmodule

bind l1_irq_agg l1_irq_chk #(
  .N_CPUS (N_CPUS),
  .N_WORDS(N_WORDS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_in        (irq_in),
  .bus_we        (bus_we),
  .bus_rdata     (bus_rdata),
  .cpu_irq       (cpu_irq),
  .dec_status_hit(dec_status_hit),
  .dec_miss      (dec_miss),
  .bank_wr       (bank_wr),
  .en_flat       (en_flat)
);

// File: tb/l1_irq_agg_bench.sv
module l1_irq_agg_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NW = 4;
  localparam int AW = 8;
  localparam int NL = NW * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] cpu_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  l1_irq_agg #(.N_CPUS(NC), .N_WORDS(NW), .ADDR_W(AW)) u_l1_irq_agg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_irq(cpu_irq)
  );

  function automatic logic [AW-1:0] en_addr(int c, int w);
    return AW'((c * 2 * NW + w) * 4);
  endfunction

  function automatic logic [AW-1:0] st_addr(int c, int w);
    return AW'((c * 2 * NW + NW + w) * 4);
  endfunction

  function automatic int word_of_line(int l);
    return NW - 1 - l / 32;
  endfunction

  function automatic logic [31:0] pattern(int c, int w);
    return 32'hC3A50000 ^ (32'(c) << 12) ^ (32'(w) * 32'h01010101);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic clear_all_en();
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) wr(en_addr(c, w), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state after reset
    rst_n = 1'b1;
    irq_in = '1;
    @(negedge clk);
    chk(cpu_irq === '0, "R1 irq after reset", 32'(cpu_irq), 32'd0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) rd_chk(en_addr(c, w), 32'd0, "R1 enable reset");
    irq_in = '0;

    // R3 R5 R8: status walking one over every line, both banks, same cycle
    for (int l = 0; l < NL; l++) begin
      @(negedge clk);
      irq_in = '0;
      irq_in[l] = 1'b1;
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < NW; w++)
          rd_chk(st_addr(c, w), (w == word_of_line(l)) ? (32'd1 << (l % 32)) : 32'd0,
                 "R3 R5 status line map");
    end
    irq_in = '0;

    // R2 R4: distinct pattern per register, read back
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) wr(en_addr(c, w), pattern(c, w));
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) rd_chk(en_addr(c, w), pattern(c, w), "R2 R4 enable readback");
    // R4: whole-word replace on one CPU only
    wr(en_addr(0, 1), 32'h0000_00F0);
    rd_chk(en_addr(0, 1), 32'h0000_00F0, "R4 full word replace");
    rd_chk(en_addr(1, 1), pattern(1, 1), "R4 other cpu untouched");

    // R5: writes to status addresses ignored
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) wr(st_addr(c, w), 32'hFFFF_FFFF);
    rd_chk(en_addr(0, 1), 32'h0000_00F0, "R5 status write ignored");
    for (int w = 0; w < NW; w++) rd_chk(en_addr(1, w), pattern(1, w), "R5 status write ignored");

    // R6: unmapped and misaligned addresses
    for (int a = NC * 2 * NW * 4; a < (1 << AW); a += 4) begin
      wr(AW'(a), 32'hFFFF_FFFF);
      rd_chk(AW'(a), 32'd0, "R6 unmapped read zero");
    end
    wr(en_addr(0, 0) + AW'(1), 32'h1234_5678);
    rd_chk(en_addr(0, 0) + AW'(1), 32'd0, "R6 misaligned read zero");
    rd_chk(en_addr(0, 0), pattern(0, 0), "R6 misaligned write ignored");
    for (int w = 0; w < NW; w++) rd_chk(en_addr(1, w), pattern(1, w), "R6 unmapped write ignored");

    // R3 R7: single enabled line per CPU, full sweep
    clear_all_en();
    for (int c = 0; c < NC; c++) begin
      for (int l = 0; l < NL; l++) begin
        wr(en_addr(c, word_of_line(l)), 32'd1 << (l % 32));
        @(negedge clk);
        irq_in = '1;
        irq_in[l] = 1'b0;
        @(negedge clk);
        chk(cpu_irq === '0, "R7 other lines masked", 32'(cpu_irq), 32'd0);
        irq_in = '0;
        irq_in[l] = 1'b1;
        #1;
        chk(cpu_irq === '0, "R7 registered latency", 32'(cpu_irq), 32'd0);
        @(negedge clk);
        chk(cpu_irq === NC'(1 << c), "R3 R7 routed line", 32'(cpu_irq), 32'(1 << c));
        irq_in = '0;
        wr(en_addr(c, word_of_line(l)), 32'd0);
      end
    end

    // R7: both CPUs on one line, then drop
    wr(en_addr(0, 3), 32'h8000_0000);
    wr(en_addr(1, 3), 32'h8000_0000);
    irq_in[31] = 1'b1;
    @(negedge clk);
    chk(cpu_irq === '1, "R7 shared line both cpus", 32'(cpu_irq), 32'(NC'('1)));
    irq_in[31] = 1'b0;
    @(negedge clk);
    chk(cpu_irq === '0, "R7 level drop clears", 32'(cpu_irq), 32'd0);

    // R1: reset again clears enables
    irq_in = '1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_irq === '0, "R1 irq after second reset", 32'(cpu_irq), 32'd0);
    rd_chk(en_addr(0, 3), 32'd0, "R1 enable cleared by reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule